// File: doc/BRIEF.md
# Sequential Shared-Adder Arithmetic Unit

This block computes one of four unsigned integer operations on two operands: sum, absolute difference, product or truncated quotient. All four run on a single adder/subtractor. A small state machine steps the operands through that adder over several clock cycles. Multiplexers in front of the adder choose its inputs and its direction on each step.

The product is built by adding the second operand into an accumulator once per count of the first operand. The quotient is built by taking the divisor away from a working dividend until the dividend falls below the divisor. A separate incrementer counts the successful subtractions, and the same incrementer counts the multiply iterations. The number of cycles each operation takes therefore depends on the operation and on the operand values.

A client presents both operands and an operation code with a one-cycle start pulse while the unit is idle. It then waits for the one-cycle done flag and reads the result, which stays put until a later operation finishes.

Top module: `seqmath_unit`

## Requirements
- R1: While reset is held and after it is released, `result` is 0 and `done` is 0 until an operation completes.
- R2: With `op_sel` = 2'b00, the unit returns `opnd_a + opnd_b` modulo 2^W. `done` rises 1 clock after the edge that accepts `start`.
- R3: With `op_sel` = 2'b01, the unit returns the absolute difference of the operands, whichever operand is larger, and 0 when they are equal. `done` rises 2 clocks after the accepting edge.
- R4: With `op_sel` = 2'b10 and `opnd_a` = x > 0, the unit returns `opnd_a * opnd_b` modulo 2^W. `done` rises 2x+1 clocks after the accepting edge.
- R5: With `op_sel` = 2'b10 and `opnd_a` = 0, the result is 0 and `done` rises 1 clock after the accepting edge.
- R6: With `op_sel` = 2'b11 and a nonzero divisor `opnd_b`, the unit returns floor(`opnd_a` / `opnd_b`) and drops any remainder. `done` rises q+2 clocks after the accepting edge, where q is the quotient. A dividend below the divisor gives 0 after 2 clocks.
- R7: With `op_sel` = 2'b11 and `opnd_b` = 0, the result is all ones and `done` rises 1 clock after the accepting edge.
- R8: `done` is high for exactly one clock per operation. `result` changes only on the clock in which `done` rises, and holds its value otherwise.
- R9: A `start` pulse that arrives while an operation is in progress is ignored. The running operation keeps its result and its latency, and it produces no second `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request; accepted only when idle |
| op_sel | input | 2 | Operation: 00 sum, 01 absolute difference, 10 product, 11 quotient |
| opnd_a | input | W (64) | First operand (multiplier count or dividend) |
| opnd_b | input | W (64) | Second operand (multiplicand or divisor) |
| result | output | W (64) | Result of the last completed operation |
| done | output | 1 | One-cycle flag marking a new valid result |

## Verification
The bench measures latency in clocks for every operation, so a state machine that skips or repeats a step shows up as a wrong cycle count even when the value is right.

The corner cases covered are these:
- Absolute difference in both operand orders and with equal operands. A comparator wired the wrong way returns a wrapped negative value.
- Multiplication with a zero count and division by zero. A design that misses either case never finishes or returns junk.
- A dividend below the divisor and an exact division. An off-by-one stop test returns one too many or one too few.
- Sums and products that overflow, which must wrap.
- A start pulse in the middle of a multiplication. A design that accepts it restarts and corrupts the product or the latency.

// File: rtl/sqa_pkg.sv
package sqa_pkg;

    localparam int unsigned SQA_WIDTH_DEF = 64;

    typedef enum logic [1:0] {
        OP_ADD    = 2'b00,
        OP_ABSDIF = 2'b01,
        OP_MUL    = 2'b10,
        OP_DIV    = 2'b11
    } op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADD,
        ST_SUB_TRIM,
        ST_SUB_SUM,
        ST_MUL_INIT,
        ST_MUL_LOAD,
        ST_MUL_ACC,
        ST_DIV_INIT,
        ST_DIV_LOOP
    } state_e;

    // Conditions the datapath reports to the sequencer
    typedef struct packed {
        logic a_zero;
        logic b_zero;
        logic a_lt_b;
        logic iter_hit;
    } cond_t;

    function automatic state_e entry_state(op_e op);
        case (op)
            OP_ADD:    return ST_ADD;
            OP_ABSDIF: return ST_SUB_TRIM;
            OP_MUL:    return ST_MUL_INIT;
            default:   return ST_DIV_INIT;
        endcase
    endfunction

endpackage

// File: rtl/sqa_addsub.sv
module sqa_addsub #(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    input  logic         sub,
    output logic [W-1:0] sum
);
    logic [W-1:0] rhs_eff;

    always_comb begin
        rhs_eff = rhs ^ {W{sub}};
        sum     = lhs + rhs_eff + W'(sub);
    end
endmodule

// File: rtl/sqa_cmp.sv
module sqa_cmp #(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    output logic         lt
);
    always_comb lt = (lhs < rhs);
endmodule

// File: rtl/sqa_qcount.sv
module sqa_qcount #(
    parameter int unsigned W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (inc)   cnt <= cnt + W'(1);
    end

    // R6
    qcount_step_chk: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr) |=> (cnt == $past(cnt) + W'(1)));
endmodule

// File: rtl/sqa_ctrl.sv
module sqa_ctrl
    import sqa_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  op_e    op,
    input  cond_t  cond,
    output state_e state
);
    state_e nxt;

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:     if (start) nxt = entry_state(op);
            ST_ADD:      nxt = ST_IDLE;
            ST_SUB_TRIM: nxt = ST_SUB_SUM;
            ST_SUB_SUM:  nxt = ST_IDLE;
            ST_MUL_INIT: nxt = cond.a_zero ? ST_IDLE : ST_MUL_LOAD;
            ST_MUL_LOAD: nxt = ST_MUL_ACC;
            ST_MUL_ACC:  nxt = cond.iter_hit ? ST_IDLE : ST_MUL_LOAD;
            ST_DIV_INIT: nxt = cond.b_zero ? ST_IDLE : ST_DIV_LOOP;
            ST_DIV_LOOP: nxt = cond.a_lt_b ? ST_IDLE : ST_DIV_LOOP;
            default:     nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MUL_LOAD) |=> (state == ST_MUL_ACC));

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !start) |=> (state == ST_IDLE));
endmodule

// File: rtl/seqmath_unit.sv
module seqmath_unit
    import sqa_pkg::*;
#(
    parameter int unsigned W = SQA_WIDTH_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [1:0]   op_sel,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    output logic [W-1:0] result,
    output logic         done
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    state_e       state;
    cond_t        cond;
    logic [W-1:0] ra, rb, tmp, acc;
    logic [W-1:0] add_l, add_r, add_sum;
    logic         add_sub;
    logic         lt;
    logic         q_clr, q_inc;
    logic [W-1:0] qcnt;

    sqa_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .op    (op_e'(op_sel)),
        .cond  (cond),
        .state (state)
    );

    sqa_cmp #(.W(W)) u_cmp (
        .lhs (ra),
        .rhs (rb),
        .lt  (lt)
    );

    sqa_addsub #(.W(W)) u_add (
        .lhs (add_l),
        .rhs (add_r),
        .sub (add_sub),
        .sum (add_sum)
    );

    sqa_qcount #(.W(W)) u_qcnt (
        .clk (clk),
        .rst (rst),
        .clr (q_clr),
        .inc (q_inc),
        .cnt (qcnt)
    );

    always_comb begin
        cond.a_zero   = (ra == '0);
        cond.b_zero   = (rb == '0);
        cond.a_lt_b   = lt;
        cond.iter_hit = (qcnt == ra);
    end

    // Operand routing into the single adder
    always_comb begin
        add_l   = ra;
        add_r   = rb;
        add_sub = 1'b0;
        case (state)
            ST_SUB_TRIM: begin
                add_l   = lt ? rb : ra;
                add_r   = lt ? ra : rb;
                add_sub = 1'b1;
            end
            ST_MUL_ACC: begin
                add_l = acc;
                add_r = tmp;
            end
            ST_DIV_LOOP: add_sub = 1'b1;
            default: ;
        endcase
    end

    always_comb begin
        q_clr = (state == ST_MUL_INIT) || (state == ST_DIV_INIT);
        q_inc = (state == ST_MUL_LOAD) || (state == ST_DIV_LOOP && !lt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ra     <= '0;
            rb     <= '0;
            tmp    <= '0;
            acc    <= '0;
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    ra <= opnd_a;
                    rb <= opnd_b;
                end
                ST_ADD: begin
                    result <= add_sum;
                    done   <= 1'b1;
                end
                ST_SUB_TRIM: begin
                    if (lt) begin
                        rb <= add_sum;
                        ra <= '0;
                    end else begin
                        ra <= add_sum;
                        rb <= '0;
                    end
                end
                ST_SUB_SUM: begin
                    result <= add_sum;
                    done   <= 1'b1;
                end
                ST_MUL_INIT: begin
                    acc <= '0;
                    if (cond.a_zero) begin
                        result <= '0;
                        done   <= 1'b1;
                    end
                end
                ST_MUL_LOAD: tmp <= rb;
                ST_MUL_ACC: begin
                    acc <= add_sum;
                    if (cond.iter_hit) begin
                        result <= add_sum;
                        done   <= 1'b1;
                    end
                end
                ST_DIV_INIT: if (cond.b_zero) begin
                    result <= ALL_ONES;
                    done   <= 1'b1;
                end
                ST_DIV_LOOP: begin
                    if (lt) begin
                        result <= qcnt;
                        done   <= 1'b1;
                    end else begin
                        ra <= add_sum;
                    end
                end
                default: ;
            endcase
        end
    end

    // R8
    done_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result));

    // R7
    div_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DIV_INIT && rb == '0) |=> (done && result == ALL_ONES));

    // R6
    div_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DIV_LOOP && lt) |=> (done && result == $past(qcnt)));
endmodule

// File: tb/seqmath_unit_tb.sv
module seqmath_unit_tb_top;
    localparam int W = 64;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [1:0]   op_sel = 2'b00;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic [W-1:0] result;
    logic         done;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    seqmath_unit #(.W(W)) dut_i (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .op_sel (op_sel),
        .opnd_a (opnd_a),
        .opnd_b (opnd_b),
        .result (result),
        .done   (done)
    );

    task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%016h expected 0x%016h", tag, got, exp);
        end
    endtask

    // Issue one operation, count clocks from accepting edge to done
    task automatic run_op(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                          output logic [W-1:0] res, output int lat);
        @(negedge clk);
        op_sel = op; opnd_a = a; opnd_b = b; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 5000) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        res = result;
    endtask

    task automatic do_case(input string tag, input logic [1:0] op, input logic [W-1:0] a,
                           input logic [W-1:0] b, input logic [W-1:0] exp, input int exp_lat);
        logic [W-1:0] r;
        int           l;
        run_op(op, a, b, r, l);
        chk({tag, " value"}, r, exp);
        chk({tag, " latency"}, W'(l), W'(exp_lat));
        @(negedge clk);
        chk({tag, " R8 done one cycle"}, W'(done), '0);
        chk({tag, " R8 result held"}, result, exp);
    endtask

    task automatic t_reset();
        // R1
        chk("R1 reset result", result, '0);
        chk("R1 reset done", W'(done), '0);
    endtask

    task automatic t_add();
        do_case("R2 add small", 2'b00, 64'd1234, 64'd8766, 64'd10000, 1);
        do_case("R2 add wrap", 2'b00, '1, 64'd2, 64'd1, 1);
    endtask

    task automatic t_sub();
        do_case("R3 absdif a>b", 2'b01, 64'd900, 64'd35, 64'd865, 2);
        do_case("R3 absdif a<b", 2'b01, 64'd35, 64'd900, 64'd865, 2);
        do_case("R3 absdif equal", 2'b01, 64'd77, 64'd77, 64'd0, 2);
        do_case("R3 absdif extreme", 2'b01, 64'd0, '1, '1, 2);
    endtask

    task automatic t_mul();
        logic [W-1:0] x, y;
        x = 64'd7; y = 64'd13;
        do_case("R4 mul", 2'b10, x, y, x * y, 2 * 7 + 1);
        x = 64'd1; y = 64'd555;
        do_case("R4 mul one", 2'b10, x, y, 64'd555, 3);
        x = 64'd3; y = 64'h8000_0000_0000_0000;
        do_case("R4 mul wrap", 2'b10, x, y, x * y, 7);
        x = 64'd5; y = '1;
        do_case("R4 mul wrap ones", 2'b10, x, y, 64'hFFFF_FFFF_FFFF_FFFB, 11);
        // R5
        do_case("R5 mul zero count", 2'b10, 64'd0, 64'd999, 64'd0, 1);
    endtask

    task automatic t_div();
        do_case("R6 div", 2'b11, 64'd100, 64'd7, 64'd14, 16);
        do_case("R6 div exact", 2'b11, 64'd42, 64'd6, 64'd7, 9);
        do_case("R6 div small dividend", 2'b11, 64'd5, 64'd9, 64'd0, 2);
        do_case("R6 div by one", 2'b11, 64'd30, 64'd1, 64'd30, 32);
        do_case("R6 div large", 2'b11, '1, 64'h8000_0000_0000_0000, 64'd1, 3);
        // R7
        do_case("R7 div by zero", 2'b11, 64'd123, 64'd0, '1, 1);
    endtask

    task automatic t_busy();
        // R9: start mid-multiply must not disturb it
        int           l;
        int           extra;
        @(negedge clk);
        op_sel = 2'b10; opnd_a = 64'd6; opnd_b = 64'd7; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        l = 0;
        while (!done && l < 5000) begin
            if (l == 3) begin
                op_sel = 2'b00; opnd_a = 64'd1; opnd_b = 64'd1; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(posedge clk);
            l++;
            @(negedge clk);
        end
        start = 1'b0;
        chk("R9 busy start value", result, 64'd42);
        chk("R9 busy start latency", W'(l), W'(13));
        extra = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (done) extra++;
        end
        chk("R9 no second done", W'(extra), '0);
        chk("R9 result kept", result, 64'd42);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_add();
        t_sub();
        t_mul();
        t_div();
        t_busy();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule